// File: doc/BRIEF.md
# Show-Ahead FIFO with Threshold Flags

This block is a single-clock, first-word-fall-through queue. A word offered on `wr_data` while `wr_en` is high is stored. The oldest word is driven on `rd_data` with `rd_valid` high, and it stays there until the consumer pulses `rd_ack` to remove it. Once the head is removed, the next stored word appears in its place. `rd_data` carries meaning only while `rd_valid` is high.

The latencies differ on purpose. A freshly written word passes through a short maturity pipeline and becomes visible three cycles after its write. The occupancy count reacts at once, and it includes words still inside that pipeline. Two comparator flags derive from this count and move one cycle after a write or an acknowledge. Because of this, `fill_flag` can be high while `rd_valid` is still low. A consumer that reads on `fill_flag` must still wait for `rd_valid`.

Misuse is reported and has no effect. A write to a full queue is dropped and pulses `overflow`. An acknowledge given while `rd_valid` is low removes nothing and pulses `ack_err`.

Top module: `show_ahead_fifo`

## Requirements
- R1: A word is accepted on every clock edge where `wr_en` is high and fewer than DEPTH words are held. Accepted words leave in the order they were written.
- R2: After a write into an empty queue, `rd_valid` is low in the first and second cycles after the write edge and high in the third.
- R3: While `rd_valid` is high and `rd_ack` is low, `rd_data` and `rd_valid` hold their values. An edge with `rd_ack` and `rd_valid` both high removes the head, and the next mature word, if any, is shown in the following cycle.
- R4: `fill_flag` is 1 exactly when the held count is strictly greater than FILL_THR. It reflects a write or an acknowledge in the cycle after that edge.
- R5: `full_flag` is 1 exactly when the held count is strictly greater than FULL_THR. It has the same one-cycle timing as `fill_flag`.
- R6: The held count includes words that are not yet visible. When an accepted write and an accepted acknowledge fall on the same edge, the count is unchanged.
- R7: A write while the count equals DEPTH is dropped, even if an acknowledge falls on the same edge. `overflow` is 1 in the following cycle, and the count never exceeds DEPTH.
- R8: `rd_ack` while `rd_valid` is low removes nothing. `ack_err` is 1 in the following cycle.
- R9: `fill_flag` may be 1 while `rd_valid` is 0. With FILL_THR=1, two writes into an empty queue give `fill_flag`=1 and `rd_valid`=0 in the cycle after the second write.
- R10: A synchronous `rst` empties the queue. In the cycle after it, `rd_valid`, `fill_flag`, `full_flag`, `overflow` and `ack_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable |
| wr_data | input | WIDTH | Word to store |
| rd_ack | input | 1 | Acknowledge: removes the shown head word |
| rd_data | output | WIDTH | Head word, meaningful while rd_valid is high |
| rd_valid | output | 1 | Head word present |
| fill_flag | output | 1 | Count greater than FILL_THR |
| full_flag | output | 1 | Count greater than FULL_THR |
| overflow | output | 1 | Pulse: a write was dropped at the previous edge |
| ack_err | output | 1 | Pulse: an acknowledge arrived while empty of visible words |

## Verification
Faults show at the ports at different speeds. A wrong count shows in the very next cycle as a wrong `fill_flag` or `full_flag` at the threshold crossings. A wrong visible-word tally shows as `rd_valid` rising too early, rising too late, or staying high on a drained queue. A read or write pointer that slips shows as a wrong `rd_data` on the next acknowledged word. If it slips only on wraparound, it shows once DEPTH words have cycled through. The bench compares every output on every cycle against a timestamped queue model, so any of these faults is reported within a cycle of reaching the ports.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    // Single-cycle misuse indications raised by the queue
    typedef struct packed {
        logic drop_wr;   // write refused: queue held DEPTH words
        logic bad_ack;   // acknowledge with no visible word
    } sfifo_evt_t;

endpackage

// File: rtl/sfifo_store.sv
module sfifo_store #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/sfifo_mature.sv
module sfifo_mature #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic in_bit,
    output logic out_bit
);

    logic [STAGES-1:0] pipe_d, pipe_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb pipe_d = in_bit;
        end else begin : g_many
            always_comb pipe_d = {pipe_q[STAGES-2:0], in_bit};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= pipe_d;
    end

    assign out_bit = pipe_q[STAGES-1];

endmodule

// File: rtl/sfifo_cmp.sv
module sfifo_cmp #(
    parameter int CW  = 4,
    parameter int THR = 1
) (
    input  logic [CW-1:0] count,
    output logic          above
);

    always_comb above = (32'(count) > THR);

endmodule

// File: rtl/show_ahead_fifo.sv
module show_ahead_fifo
    import sfifo_pkg::*;
#(
    parameter int WIDTH     = 16,
    parameter int DEPTH     = 8,
    parameter int FILL_THR  = 1,
    parameter int FULL_THR  = 6,
    parameter int VALID_LAT = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_ack,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid,
    output logic             fill_flag,
    output logic             full_flag,
    output logic             overflow,
    output logic             ack_err
);

    localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW     = $clog2(DEPTH + 1);
    localparam int STAGES = VALID_LAT - 1;
    localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
    localparam logic [AW-1:0] PTR_MAX = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;   // all held words, visible or not
        logic [CW-1:0] avail;   // words that have reached the output
        sfifo_evt_t    evt;
    } state_t;

    state_t st_d, st_q;
    logic   push, pop, matured;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == PTR_MAX) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        push = wr_en && (st_q.count != CNT_MAX);
        pop  = rd_ack && (st_q.avail != '0);

        if (push) st_d.wr_ptr = bump(st_q.wr_ptr);
        if (pop)  st_d.rd_ptr = bump(st_q.rd_ptr);

        st_d.count = st_q.count + CW'(push) - CW'(pop);
        st_d.avail = st_q.avail + CW'(matured) - CW'(pop);

        st_d.evt.drop_wr = wr_en && (st_q.count == CNT_MAX);
        st_d.evt.bad_ack = rd_ack && (st_q.avail == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    sfifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (push),
        .waddr (st_q.wr_ptr),
        .wdata (wr_data),
        .raddr (st_q.rd_ptr),
        .rdata (rd_data)
    );

    sfifo_mature #(.STAGES(STAGES)) u_mature (
        .clk     (clk),
        .rst     (rst),
        .in_bit  (push),
        .out_bit (matured)
    );

    sfifo_cmp #(.CW(CW), .THR(FILL_THR)) u_fill_cmp (
        .count (st_q.count),
        .above (fill_flag)
    );

    sfifo_cmp #(.CW(CW), .THR(FULL_THR)) u_full_cmp (
        .count (st_q.count),
        .above (full_flag)
    );

    assign rd_valid = (st_q.avail != '0);
    assign overflow = st_q.evt.drop_wr;
    assign ack_err  = st_q.evt.bad_ack;

endmodule

// File: rtl/show_ahead_fifo_chk.sv
module show_ahead_fifo_chk #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             rd_ack,
    input logic [WIDTH-1:0] rd_data,
    input logic             rd_valid,
    input logic             fill_flag,
    input logic             full_flag,
    input logic             overflow,
    input logic             ack_err,
    input logic [CW-1:0]    count
);

    localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

    p_valid_latency_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_valid) |-> $past(wr_en, 3));

    p_head_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ack) |=> (rd_valid && $stable(rd_data)));

    p_same_edge_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_ack && rd_valid && count != CNT_MAX) |=> $stable(count));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_MAX);

    p_drop_cause_r7: assert property (@(posedge clk) disable iff (rst)
        overflow |-> ($past(wr_en) && $past(count) == CNT_MAX));

    p_bad_ack_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_ack && !rd_valid) |=> ack_err);

    p_bad_ack_nopop_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_ack && !rd_valid && !wr_en) |=> $stable(count));

    p_reset_clear_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rd_valid && !fill_flag && !full_flag && !overflow && !ack_err));

endmodule

bind show_ahead_fifo show_ahead_fifo_chk #(
    .WIDTH (WIDTH),
    .DEPTH (DEPTH),
    .CW    ($clog2(DEPTH + 1))
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_ack    (rd_ack),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .fill_flag (fill_flag),
    .full_flag (full_flag),
    .overflow  (overflow),
    .ack_err   (ack_err),
    .count     (st_q.count)
);

// File: tb/show_ahead_fifo_tb.sv
`timescale 1ns/1ps
module show_ahead_fifo_tb;

    localparam int W    = 16;
    localparam int DEP  = 8;
    localparam int FILL = 1;
    localparam int FULL = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         rd_ack = 1'b0;
    logic [W-1:0] rd_data;
    logic         rd_valid, fill_flag, full_flag, overflow, ack_err;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // reference model
    logic [W-1:0] mq[$];
    int           mt[$];
    int           cyc = 0;
    bit           e_ovf = 1'b0;
    bit           e_err = 1'b0;

    always #10 clk = ~clk;

    show_ahead_fifo #(.WIDTH(W), .DEPTH(DEP), .FILL_THR(FILL), .FULL_THR(FULL)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_ack(rd_ack),
        .rd_data(rd_data), .rd_valid(rd_valid), .fill_flag(fill_flag),
        .full_flag(full_flag), .overflow(overflow), .ack_err(ack_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic bit m_valid();
        return (mq.size() > 0) && (cyc - mt[0] >= 3);
    endfunction

    task automatic m_update(input bit r, input bit w, input logic [W-1:0] d, input bit a);
        bit vb;
        int sz;
        vb = m_valid();
        sz = mq.size();
        if (r) begin
            mq.delete(); mt.delete();
            e_ovf = 1'b0; e_err = 1'b0;
        end else begin
            e_ovf = w && (sz == DEP);
            e_err = a && !vb;
            if (a && vb) begin
                void'(mq.pop_front()); void'(mt.pop_front());
            end
            if (w && sz < DEP) begin
                mq.push_back(d); mt.push_back(cyc);
            end
        end
        cyc++;
    endtask

    task automatic compare();
        bit ev;
        ev = m_valid();
        chk("R2 rd_valid", 32'(rd_valid), 32'(ev));
        if (ev) chk("R1/R3 rd_data", 32'(rd_data), 32'(mq[0]));
        chk("R4 fill_flag", 32'(fill_flag), 32'(mq.size() > FILL));
        chk("R5 full_flag", 32'(full_flag), 32'(mq.size() > FULL));
        chk("R7 overflow", 32'(overflow), 32'(e_ovf));
        chk("R8 ack_err", 32'(ack_err), 32'(e_err));
    endtask

    // drive at negedge, model at posedge, compare at next negedge
    task automatic step(input bit r, input bit w, input logic [W-1:0] d, input bit a);
        rst = r; wr_en = w; wr_data = d; rd_ack = a;
        @(posedge clk);
        m_update(r, w, d, a);
        @(negedge clk);
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(1'b1, 1'b0, '0, 1'b0);
        step(1'b1, 1'b0, '0, 1'b0);
        // R10: reset state
        chk("R10 rd_valid after reset", 32'(rd_valid), 0);
        chk("R10 fill_flag after reset", 32'(fill_flag), 0);
        chk("R10 full_flag after reset", 32'(full_flag), 0);

        // R2: three-cycle write-to-valid
        step(1'b0, 1'b1, 16'hA1A1, 1'b0);
        chk("R2 valid low cycle 1", 32'(rd_valid), 0);
        step(1'b0, 1'b0, '0, 1'b0);
        chk("R2 valid low cycle 2", 32'(rd_valid), 0);
        step(1'b0, 1'b0, '0, 1'b0);
        chk("R2 valid high cycle 3", 32'(rd_valid), 1);
        chk("R3 head data", 32'(rd_data), 32'h0000A1A1);
        idle(3);
        chk("R3 head held without ack", 32'(rd_data), 32'h0000A1A1);
        step(1'b0, 1'b0, '0, 1'b1);
        chk("R3 popped to empty", 32'(rd_valid), 0);

        // R8: acknowledge on empty
        step(1'b0, 1'b0, '0, 1'b1);
        chk("R8 ack_err pulse", 32'(ack_err), 1);
        step(1'b0, 1'b0, '0, 1'b0);
        chk("R8 ack_err clears", 32'(ack_err), 0);

        // R9: fill high while valid low
        step(1'b0, 1'b1, 16'h0B01, 1'b0);
        step(1'b0, 1'b1, 16'h0B02, 1'b0);
        chk("R9 fill_flag high", 32'(fill_flag), 1);
        chk("R9 rd_valid still low", 32'(rd_valid), 0);
        // R8: premature ack ignored, head still B01 later
        step(1'b0, 1'b0, '0, 1'b1);
        chk("R8 premature ack flagged", 32'(ack_err), 1);
        chk("R8 premature ack no pop", 32'(rd_data), 32'h00000B01);

        // R1/R5/R7: fill to DEPTH then overflow, also with ack on same edge
        for (int i = 3; i <= DEP; i++) step(1'b0, 1'b1, 16'(16'h0B00 + i), 1'b0);
        chk("R5 full_flag at depth", 32'(full_flag), 1);
        step(1'b0, 1'b1, 16'hDEAD, 1'b0);
        chk("R7 overflow pulse", 32'(overflow), 1);
        step(1'b0, 1'b1, 16'hBEEF, 1'b1);
        chk("R7 dropped with same-edge ack", 32'(overflow), 1);
        // R6: write and ack together keep count
        step(1'b0, 1'b1, 16'h0C01, 1'b1);
        step(1'b0, 1'b1, 16'h0C02, 1'b1);
        chk("R6 count kept (full_flag)", 32'(full_flag), 1);
        // drain in order
        for (int i = 0; i < 12; i++) step(1'b0, 1'b0, '0, 1'b1);
        chk("R1 drained", 32'(rd_valid), 0);

        // random traffic
        for (int i = 0; i < 3000; i++)
            step(1'b0, 1'($urandom_range(0, 2) != 0), 16'($urandom),
                 1'($urandom_range(0, 2) != 0));
        for (int i = 0; i < 2000; i++)
            step(1'b0, 1'($urandom_range(0, 3) == 0), 16'($urandom),
                 1'($urandom_range(0, 1)));

        // R10: reset with contents
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 16'(i), 1'b0);
        step(1'b1, 1'b1, 16'h7777, 1'b1);
        chk("R10 valid cleared", 32'(rd_valid), 0);
        chk("R10 fill cleared", 32'(fill_flag), 0);
        idle(4);
        chk("R10 stays empty", 32'(rd_valid), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule